// File: doc/BRIEF.md
# Line-Protected RAM with Check-Bit Validity Tracking

This block is a single-port on-chip RAM built from 128-bit lines. Beside the data array sits a check store that holds, for each line, a 4-bit error-detection code and a valid flag. When a write supplies all sixteen bytes of a line, the block computes a new code and marks the line as trusted. A write that supplies fewer bytes updates only the enabled bytes. It also marks the line's code as unusable by clearing the flag and zeroing the code. The block never reads the old contents to merge a partial write.

Detection is controlled by one bit in a command register. It is off after reset. Turning it on leaves the check store as it is. A line that was never written may therefore still carry a set flag with a code that does not match its data, and reading such a line reports an error. Every read returns the stored data unchanged. A read raises a one-cycle error pulse only when three things hold: detection was on when the read was issued, the line's flag is set, and the recomputed code differs from the stored one. On each error, the failing line address is captured and held until the next error.

Top module: `prp_ram`

## Requirements
- R1: A write changes exactly the bytes whose enable bit is 1. Byte b of the mask covers data bits [8b+7:8b]. A read issued in cycle t returns the whole stored line with rd_valid high two clock edges later, and the data is never altered, whether or not an error is flagged.
- R2: A write with all 16 byte enables set (16'hFFFF) stores a freshly computed code and sets the line's valid flag, so a later read of that unchanged line with detection on raises no error.
- R3: A write with any mask other than 16'hFFFF, including 16'h0000, clears the line's valid flag and zeroes its code. A later read of that line raises no error, even if the flag was previously set with a wrong code.
- R4: Detection is off after reset. A command write (cmd_we=1) sets the detection state to cmd_wdata bit 0, where 1 means on and 0 means off.
- R5: Switching detection on does not modify the check store. A line left with a set valid flag and a non-matching code raises an error on its first read after enabling.
- R6: The code has one even-parity bit per 32-bit word: code bit k is the XOR of data bits [32k+31:32k]. When detection is on and the flag is set, any differing code bit gives err_pulse=1 for exactly the cycle in which rd_valid is high for that read.
- R7: A read of a line whose valid flag is clear, or a read issued while detection is off, never raises err_pulse.
- R8: err_addr takes the line address of the failing read in the same cycle as err_pulse. It holds that value through later error-free reads until the next error. It is 0 after reset.
- R9: A read uses the detection state as it stood before any command write in the same cycle. A command write and a read issued together judge the read by the previous state.
- R10: A full-line write to a line that carried a stale valid flag and a wrong code removes the false error for that line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 means write, 0 means read |
| req_addr | input | AW | Line address |
| req_be | input | 16 | Byte-enable mask for writes |
| req_wdata | input | 128 | Write data |
| cmd_we | input | 1 | Command register write strobe |
| cmd_wdata | input | 32 | Command word; bit 0 is the detection enable |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 128 | Read data |
| err_pulse | output | 1 | One-cycle check failure flag |
| err_addr | output | AW | Line address of the most recent failure |

## Verification
A command write and a line read can fall in the same clock cycle, and the read must be judged by the detection state that stood before the write. The bench provokes this in both directions. It issues an enabling command together with a read of a deliberately corrupted line and expects no error. It then reads the same line again and expects an error. Finally it issues a disabling command together with a read and expects that read still to be flagged, with the read that follows it clean.

// File: rtl/prp_pkg.sv
package prp_pkg;

    localparam int LINE_BYTES = 16;
    localparam int BYTE_BITS  = 8;
    localparam int LINE_BITS  = LINE_BYTES * BYTE_BITS;
    localparam int WORD_BITS  = 32;
    localparam int WORDS      = LINE_BITS / WORD_BITS;
    localparam int CMD_BITS   = 32;
    localparam int CMD_EN_BIT = 0;

    typedef logic [LINE_BITS-1:0]  line_t;
    typedef logic [LINE_BYTES-1:0] be_t;
    typedef logic [WORDS-1:0]      code_t;

    typedef struct packed {
        logic  valid;
        code_t code;
    } chk_t;

    typedef enum logic [1:0] {
        OP_IDLE       = 2'd0,
        OP_READ       = 2'd1,
        OP_WRITE_FULL = 2'd2,
        OP_WRITE_PART = 2'd3
    } op_e;

    function automatic code_t calc_code(input line_t d);
        code_t c;
        for (int w = 0; w < WORDS; w++) begin
            c[w] = ^d[w*WORD_BITS +: WORD_BITS];
        end
        return c;
    endfunction

    function automatic op_e decode_op(input logic vld, input logic wr, input be_t be);
        if (!vld)     return OP_IDLE;
        if (!wr)      return OP_READ;
        if (&be)      return OP_WRITE_FULL;
        return OP_WRITE_PART;
    endfunction

endpackage

// File: rtl/prp_cmd_reg.sv
module prp_cmd_reg
    import prp_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                cmd_we,
    input  logic [CMD_BITS-1:0] cmd_wdata,
    output logic                det_en
);

    always_ff @(posedge clk) begin
        if (rst) begin
            det_en <= 1'b0;
        end else if (cmd_we) begin
            det_en <= cmd_wdata[CMD_EN_BIT];
        end
    end

    // R4
    det_off_after_reset_chk: assert property (@(posedge clk)
        $past(rst) |-> !det_en);

endmodule

// File: rtl/prp_data_array.sv
module prp_data_array
    import prp_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [AW-1:0] addr,
    input  be_t           be,
    input  line_t         wdata,
    output line_t         rdata
);

    line_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            for (int b = 0; b < LINE_BYTES; b++) begin
                if (be[b]) begin
                    mem[addr][b*BYTE_BITS +: BYTE_BITS] <= wdata[b*BYTE_BITS +: BYTE_BITS];
                end
            end
        end
        if (rd_en) begin
            rdata <= mem[addr];
        end
    end

endmodule

// File: rtl/prp_check_store.sv
module prp_check_store
    import prp_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic          wr_full,
    input  code_t         wr_code,
    input  logic          rd_en,
    input  logic [AW-1:0] addr,
    output chk_t          rdata
);

    chk_t mem [DEPTH];
    chk_t wr_entry;

    always_comb begin
        wr_entry = '0;
        if (wr_full) begin
            wr_entry.valid = 1'b1;
            wr_entry.code  = wr_code;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[addr] <= wr_entry;
        end
        if (rd_en) begin
            rdata <= mem[addr];
        end
    end

    // R3
    part_write_zeroes_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_full) |=> (mem[$past(addr)] == '0));

    // R2
    full_write_marks_valid_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_full) |=> mem[$past(addr)].valid);

endmodule

// File: rtl/prp_check_eval.sv
module prp_check_eval
    import prp_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          s1_rd,
    input  logic          s1_en,
    input  logic [AW-1:0] s1_addr,
    input  line_t         s1_data,
    input  chk_t          s1_chk,
    output logic          rd_valid,
    output line_t         rd_data,
    output logic          err_pulse,
    output logic [AW-1:0] err_addr
);

    logic  mismatch;
    code_t fresh;

    always_comb begin
        fresh    = calc_code(s1_data);
        mismatch = s1_rd && s1_en && s1_chk.valid && (fresh != s1_chk.code);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid  <= 1'b0;
            err_pulse <= 1'b0;
            err_addr  <= '0;
            rd_data   <= '0;
        end else begin
            rd_valid  <= s1_rd;
            err_pulse <= mismatch;
            if (s1_rd) begin
                rd_data <= s1_data;
            end
            if (mismatch) begin
                err_addr <= s1_addr;
            end
        end
    end

    // R6
    err_with_data_chk: assert property (@(posedge clk) disable iff (rst)
        err_pulse |-> rd_valid);

    // R7
    err_needs_check_chk: assert property (@(posedge clk) disable iff (rst)
        err_pulse |-> $past(s1_en && s1_chk.valid));

    // R8
    err_addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !err_pulse |-> $stable(err_addr));

endmodule

// File: rtl/prp_ram.sv
module prp_ram
    import prp_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [AW-1:0]        req_addr,
    input  logic [LINE_BYTES-1:0] req_be,
    input  logic [LINE_BITS-1:0] req_wdata,
    input  logic                 cmd_we,
    input  logic [CMD_BITS-1:0]  cmd_wdata,
    output logic                 rd_valid,
    output logic [LINE_BITS-1:0] rd_data,
    output logic                 err_pulse,
    output logic [AW-1:0]        err_addr
);

    op_e     op;
    logic    wr_en;
    logic    wr_full;
    logic    rd_en;
    code_t   wr_code;
    logic    det_en;
    logic    s1_rd;
    logic    s1_en;
    logic [AW-1:0] s1_addr;
    line_t   s1_data;
    chk_t    s1_chk;

    always_comb begin
        op      = decode_op(req_valid, req_write, req_be);
        wr_en   = (op == OP_WRITE_FULL) || (op == OP_WRITE_PART);
        wr_full = (op == OP_WRITE_FULL);
        rd_en   = (op == OP_READ);
        wr_code = calc_code(req_wdata);
    end

    prp_cmd_reg u_cmd (
        .clk       (clk),
        .rst       (rst),
        .cmd_we    (cmd_we),
        .cmd_wdata (cmd_wdata),
        .det_en    (det_en)
    );

    prp_data_array #(.DEPTH(DEPTH), .AW(AW)) u_data (
        .clk   (clk),
        .wr_en (wr_en),
        .rd_en (rd_en),
        .addr  (req_addr),
        .be    (req_be),
        .wdata (req_wdata),
        .rdata (s1_data)
    );

    prp_check_store #(.DEPTH(DEPTH), .AW(AW)) u_chk (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_full (wr_full),
        .wr_code (wr_code),
        .rd_en   (rd_en),
        .addr    (req_addr),
        .rdata   (s1_chk)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_rd   <= 1'b0;
            s1_en   <= 1'b0;
            s1_addr <= '0;
        end else begin
            s1_rd <= rd_en;
            s1_en <= det_en;
            if (rd_en) begin
                s1_addr <= req_addr;
            end
        end
    end

    prp_check_eval #(.AW(AW)) u_eval (
        .clk       (clk),
        .rst       (rst),
        .s1_rd     (s1_rd),
        .s1_en     (s1_en),
        .s1_addr   (s1_addr),
        .s1_data   (s1_data),
        .s1_chk    (s1_chk),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data),
        .err_pulse (err_pulse),
        .err_addr  (err_addr)
    );

    // R1
    read_latency_chk: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $past(s1_rd));

    // R9
    enable_sampled_at_read_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && cmd_we) |=> (s1_en == $past(det_en)));

endmodule

// File: tb/prp_ram_test.sv
module prp_ram_test;
    import prp_pkg::*;

    localparam int DEPTH = 64;
    localparam int AW    = $clog2(DEPTH);

    logic          clk = 1'b0;
    logic          rst;
    logic          req_valid, req_write;
    logic [AW-1:0] req_addr;
    logic [15:0]   req_be;
    logic [127:0]  req_wdata;
    logic          cmd_we;
    logic [31:0]   cmd_wdata;
    logic          rd_valid;
    logic [127:0]  rd_data;
    logic          err_pulse;
    logic [AW-1:0] err_addr;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    prp_ram #(.DEPTH(DEPTH)) uut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_be(req_be), .req_wdata(req_wdata),
        .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data),
        .err_pulse(err_pulse), .err_addr(err_addr)
    );

    function automatic logic [3:0] par4(input logic [127:0] d);
        logic [3:0] c;
        for (int k = 0; k < 4; k++) c[k] = ^d[32*k +: 32];
        return c;
    endfunction

    function automatic logic [127:0] merge(input logic [127:0] old_d, input logic [127:0] new_d,
                                           input logic [15:0] be);
        logic [127:0] r = old_d;
        for (int b = 0; b < 16; b++) if (be[b]) r[8*b +: 8] = new_d[8*b +: 8];
        return r;
    endfunction

    task automatic check(input string req, input string what, input logic [127:0] got,
                         input logic [127:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic idle();
        req_valid = 1'b0; req_write = 1'b0; req_addr = '0;
        req_be = '0; req_wdata = '0; cmd_we = 1'b0; cmd_wdata = '0;
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [15:0] be, input logic [127:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_be = be; req_wdata = d;
        @(negedge clk);
        idle();
    endtask

    task automatic do_cmd(input logic en);
        @(negedge clk);
        cmd_we = 1'b1; cmd_wdata = {31'd0, en};
        @(negedge clk);
        idle();
    endtask

    // Issues a read (optionally with a command write in the same cycle) and
    // samples the outputs after the second rising edge.
    task automatic do_read(input logic [AW-1:0] a, input logic with_cmd, input logic cmd_en,
                           output logic [127:0] d, output logic e, output logic [AW-1:0] ea);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        cmd_we = with_cmd; cmd_wdata = {31'd0, cmd_en};
        @(negedge clk);
        idle();
        @(negedge clk);
        d = rd_data; e = err_pulse; ea = err_addr;
        n_checks++;
        if (rd_valid !== 1'b1) begin
            n_fail++;
            $display("FAIL R1 rd_valid: got %b expected 1", rd_valid);
        end
    endtask

    task automatic preload(input int a, input logic [127:0] d, input logic v, input logic [3:0] c);
        uut.u_data.mem[a] = d;
        uut.u_chk.mem[a]  = {v, c};
    endtask

    logic [127:0] rd;
    logic         er;
    logic [AW-1:0] ea;
    localparam logic [127:0] STALE3 = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210;
    localparam logic [127:0] PAT_A  = 128'hDEAD_BEEF_0000_FFFF_1234_5678_A5A5_5A5A;
    localparam logic [127:0] PAT_B  = 128'h1111_2222_3333_4444_5555_6666_7777_8888;

    task automatic t_reset();
        @(negedge clk);
        check("R4", "rd_valid after reset", {127'd0, rd_valid}, 128'd0);
        check("R8", "err_addr after reset", {{(128-AW){1'b0}}, err_addr}, 128'd0);
        check("R6", "err_pulse after reset", {127'd0, err_pulse}, 128'd0);
    endtask

    task automatic t_disabled_stale();
        do_read(3, 1'b0, 1'b0, rd, er, ea);
        check("R7", "no error while disabled", {127'd0, er}, 128'd0);
        check("R1", "stale data returned", rd, STALE3);
    endtask

    task automatic t_enable_stale();
        do_cmd(1'b1);
        do_read(3, 1'b0, 1'b0, rd, er, ea);
        check("R5", "stale valid entry flags after enable", {127'd0, er}, 128'd1);
        check("R8", "err_addr of stale line", {{(128-AW){1'b0}}, ea}, 128'd3);
        check("R1", "data unchanged on error", rd, STALE3);
        @(negedge clk);
        check("R6", "error is one cycle", {127'd0, err_pulse}, 128'd0);
    endtask

    task automatic t_full_write();
        do_write(3, 16'hFFFF, PAT_A);
        do_read(3, 1'b0, 1'b0, rd, er, ea);
        check("R10", "full write clears false error", {127'd0, er}, 128'd0);
        check("R2", "full write data", rd, PAT_A);
        check("R8", "err_addr held", {{(128-AW){1'b0}}, ea}, 128'd3);
    endtask

    task automatic t_partial();
        do_write(5, 16'h00F0, PAT_B);
        do_read(5, 1'b0, 1'b0, rd, er, ea);
        check("R3", "partial write clears stale flag", {127'd0, er}, 128'd0);
        check("R1", "byte merge", rd, merge(PAT_A, PAT_B, 16'h00F0));
        do_write(6, 16'h0000, PAT_B);
        do_read(6, 1'b0, 1'b0, rd, er, ea);
        check("R3", "empty mask clears stale flag", {127'd0, er}, 128'd0);
        check("R1", "empty mask keeps data", rd, PAT_A);
    endtask

    task automatic t_parity_detect();
        logic [127:0] bad;
        do_write(7, 16'hFFFF, PAT_B);
        bad = PAT_B ^ (128'd1 << 70);
        uut.u_data.mem[7] = bad;
        do_read(7, 1'b0, 1'b0, rd, er, ea);
        check("R6", "single-bit corruption flagged", {127'd0, er}, 128'd1);
        check("R8", "err_addr moves to 7", {{(128-AW){1'b0}}, ea}, 128'd7);
        check("R1", "corrupt data returned as stored", rd, bad);
        do_read(3, 1'b0, 1'b0, rd, er, ea);
        check("R6", "good line no error", {127'd0, er}, 128'd0);
        check("R8", "err_addr held after clean read", {{(128-AW){1'b0}}, ea}, 128'd7);
        do_read(9, 1'b0, 1'b0, rd, er, ea);
        check("R7", "invalid line with garbage code", {127'd0, er}, 128'd0);
    endtask

    task automatic t_disable_and_same_cycle();
        do_cmd(1'b0);
        do_read(7, 1'b0, 1'b0, rd, er, ea);
        check("R4", "disabled by command bit 0", {127'd0, er}, 128'd0);
        do_read(7, 1'b1, 1'b1, rd, er, ea);
        check("R9", "enable with read uses old state", {127'd0, er}, 128'd0);
        do_read(7, 1'b0, 1'b0, rd, er, ea);
        check("R9", "next read sees enable", {127'd0, er}, 128'd1);
        do_read(7, 1'b1, 1'b0, rd, er, ea);
        check("R9", "disable with read uses old state", {127'd0, er}, 128'd1);
        do_read(7, 1'b0, 1'b0, rd, er, ea);
        check("R7", "after disable no error", {127'd0, er}, 128'd0);
    endtask

    initial begin
        idle();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        preload(3, STALE3, 1'b1, ~par4(STALE3));
        preload(5, PAT_A,  1'b1, ~par4(PAT_A));
        preload(6, PAT_A,  1'b1, par4(PAT_A) ^ 4'b0010);
        preload(9, PAT_A,  1'b0, 4'b1010);
        t_reset();
        t_disabled_stale();
        t_enable_stale();
        t_full_write();
        t_partial();
        t_parity_detect();
        t_disable_and_same_cycle();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule